// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), where each operand of an instruction should come from when an older instruction that has not yet written the register file produces that operand. It looks at the source register numbers of the instruction in execute and at the store-data register of the instruction in memory. It compares them with the destination register numbers, write enables and load flags held in the execute/memory and memory/writeback pipeline registers. For each operand it drives a select code and the chosen value, ready to feed the operand muxes in the same cycle.

There are two execute-stage operands. The first carries the base address for loads and stores, and the second carries the store data. The memory stage also has a late store-data path. A store whose data comes from a load one slot ahead can take the loaded value straight from the writeback side, without waiting for it in execute. The unit is purely combinational. Stall generation, branch hazards and the register file are handled elsewhere. Dependencies three or more instructions apart need nothing from this unit, because the register file write lands in the reader's decode cycle.

Top module: `fwd_unit`

## Requirements
- R1: With no matching in-flight producer, each execute operand select is 2'b00 and the operand value equals the register file value given for it.
- R2: When the execute/memory producer is not a load, has its write enable high, has a nonzero destination, and that destination equals an execute source, that operand's select is 2'b01 and its value is the execute/memory result.
- R3: When only the memory/writeback producer matches an execute source (write enable high, nonzero destination), that operand's select is 2'b10 and its value is the writeback value. This includes data returned by a load.
- R4: When both producers match the same execute source, the execute/memory producer (the younger one) wins, giving select 2'b01.
- R5: A load held in the execute/memory register never sources an execute operand. The operand falls back to a writeback match if there is one, and otherwise to the register file value.
- R6: Register 0 is never forwarded, and a producer whose write enable is low never matches, on every path.
- R7: When the instruction in memory is a store and the writeback producer matches its store-data register, the store-data select is 1 and the store-data value is the writeback value. Otherwise the select is 0 and the value is the store data carried in the execute/memory register.
- R8: The base and data registers of a store in execute are resolved independently. A data register written two instructions earlier gets select 2'b10 on the second operand, while an unrelated base keeps 2'b00.
- R9: When the memory-stage instruction is not a store, the store-data select stays 0 even if its register field matches the writeback destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | First source register of the instruction in execute (base for memory ops) |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute (store data) |
| ex_rf_a | input | DATA_W | Register file value read for the first source |
| ex_rf_b | input | DATA_W | Register file value read for the second source |
| xm_dst | input | REG_AW | Destination register in the execute/memory register |
| xm_wen | input | 1 | Write enable in the execute/memory register |
| xm_is_load | input | 1 | Execute/memory instruction is a load |
| xm_result | input | DATA_W | ALU result in the execute/memory register |
| xm_is_store | input | 1 | Execute/memory instruction is a store |
| xm_sd_src | input | REG_AW | Store-data register of the memory-stage instruction |
| xm_sd_val | input | DATA_W | Store data carried in the execute/memory register |
| mw_dst | input | REG_AW | Destination register in the memory/writeback register |
| mw_wen | input | 1 | Write enable in the memory/writeback register |
| mw_val | input | DATA_W | Value being written back (ALU result or load data) |
| op_a_sel | output | 2 | Source code for the first operand: 00 register file, 01 execute/memory, 10 writeback |
| op_b_sel | output | 2 | Source code for the second operand, same encoding |
| op_a_val | output | DATA_W | Resolved first operand |
| op_b_val | output | DATA_W | Resolved second operand |
| sd_sel | output | 1 | Late store-data source: 1 writeback, 0 carried value |
| sd_val | output | DATA_W | Resolved store data for the memory stage |

## Verification
The bench drives the producer/consumer pairs found in real code. Back-to-back ALU use separates the 2'b01 path from the 2'b10 path. A one-gap dependency checks the older boundary alone. A double match on one register exposes a wrong priority. A load sitting one slot ahead shows whether its address is wrongly forwarded in place of waiting for its data. Store patterns (load directly followed by a store, store two behind its writer, and a non-store with a matching field) separate the late memory-stage path from the execute path and from each other. Register 0 and disabled writers with matching numbers catch matching that is missing its qualifiers.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_XM  = 2'b01,
    FWD_MW  = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_EX_SRC = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wen,
  input  logic              blocked,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wen && !blocked && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/fwd_ex_sel.sv
module fwd_ex_sel
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [REG_AW-1:0] xm_dst,
  input  logic              xm_wen,
  input  logic              xm_is_load,
  input  logic [DATA_W-1:0] xm_result,
  input  logic [REG_AW-1:0] mw_dst,
  input  logic              mw_wen,
  input  logic [DATA_W-1:0] mw_val,
  output fwd_sel_e          sel,
  output logic [DATA_W-1:0] val
);
  logic hit_xm;
  logic hit_mw;

  // a load in execute/memory holds an address, not data
  fwd_match #(.REG_AW(REG_AW)) u_m_xm (
    .src(src), .dst(xm_dst), .wen(xm_wen), .blocked(xm_is_load), .hit(hit_xm)
  );

  fwd_match #(.REG_AW(REG_AW)) u_m_mw (
    .src(src), .dst(mw_dst), .wen(mw_wen), .blocked(1'b0), .hit(hit_mw)
  );

  always_comb begin
    if (hit_xm) begin
      sel = FWD_XM;
      val = xm_result;
    end else if (hit_mw) begin
      sel = FWD_MW;
      val = mw_val;
    end else begin
      sel = FWD_RF;
      val = rf_val;
    end
  end
endmodule

// File: rtl/fwd_sd_sel.sv
module fwd_sd_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              xm_is_store,
  input  logic [REG_AW-1:0] xm_sd_src,
  input  logic [DATA_W-1:0] xm_sd_val,
  input  logic [REG_AW-1:0] mw_dst,
  input  logic              mw_wen,
  input  logic [DATA_W-1:0] mw_val,
  output logic              sel,
  output logic [DATA_W-1:0] val
);
  logic hit;

  fwd_match #(.REG_AW(REG_AW)) u_m_sd (
    .src(xm_sd_src), .dst(mw_dst), .wen(mw_wen), .blocked(!xm_is_store), .hit(hit)
  );

  always_comb begin
    sel = hit;
    val = hit ? mw_val : xm_sd_val;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  input  logic [REG_AW-1:0] xm_dst,
  input  logic              xm_wen,
  input  logic              xm_is_load,
  input  logic [DATA_W-1:0] xm_result,
  input  logic              xm_is_store,
  input  logic [REG_AW-1:0] xm_sd_src,
  input  logic [DATA_W-1:0] xm_sd_val,
  input  logic [REG_AW-1:0] mw_dst,
  input  logic              mw_wen,
  input  logic [DATA_W-1:0] mw_val,
  output logic [1:0]        op_a_sel,
  output logic [1:0]        op_b_sel,
  output logic [DATA_W-1:0] op_a_val,
  output logic [DATA_W-1:0] op_b_val,
  output logic              sd_sel,
  output logic [DATA_W-1:0] sd_val
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] src_arr [NUM_EX_SRC];
  logic [DATA_W-1:0] rf_arr  [NUM_EX_SRC];
  fwd_sel_e          sel_arr [NUM_EX_SRC];
  logic [DATA_W-1:0] val_arr [NUM_EX_SRC];

  always_comb begin
    src_arr[0] = ex_src_a;
    src_arr[1] = ex_src_b;
    rf_arr[0]  = ex_rf_a;
    rf_arr[1]  = ex_rf_b;
  end

  for (genvar gi = 0; gi < NUM_EX_SRC; gi++) begin : g_ex_op
    fwd_ex_sel #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ex_sel (
      .src       (src_arr[gi]),
      .rf_val    (rf_arr[gi]),
      .xm_dst    (xm_dst),
      .xm_wen    (xm_wen),
      .xm_is_load(xm_is_load),
      .xm_result (xm_result),
      .mw_dst    (mw_dst),
      .mw_wen    (mw_wen),
      .mw_val    (mw_val),
      .sel       (sel_arr[gi]),
      .val       (val_arr[gi])
    );
  end

  fwd_sd_sel #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_sd_sel (
    .xm_is_store(xm_is_store),
    .xm_sd_src  (xm_sd_src),
    .xm_sd_val  (xm_sd_val),
    .mw_dst     (mw_dst),
    .mw_wen     (mw_wen),
    .mw_val     (mw_val),
    .sel        (sd_sel),
    .val        (sd_val)
  );

  always_comb begin
    op_a_sel = sel_arr[0];
    op_b_sel = sel_arr[1];
    op_a_val = val_arr[0];
    op_b_val = val_arr[1];
  end

  // checks on the combined outputs of the per-operand selectors
  always_comb begin
    // R2, R5: an execute/memory forward never comes from a load or a disabled writer
    assert_xm_fwd_qualified_R5: assert (!(op_a_sel == 2'b01 && (xm_is_load || !xm_wen)))
      else $error("op_a forwarded from load or disabled writer");
    assert_xm_fwd_qualified_b_R5: assert (!(op_b_sel == 2'b01 && (xm_is_load || !xm_wen)))
      else $error("op_b forwarded from load or disabled writer");
    // R6: register 0 never forwarded
    assert_no_zero_fwd_R6: assert (!(op_a_sel != 2'b00 && ex_src_a == ZERO_REG))
      else $error("register 0 forwarded on op_a");
    assert_no_zero_sd_R6: assert (!(sd_sel && xm_sd_src == ZERO_REG))
      else $error("register 0 forwarded to store data");
    // R9: late store path only for stores
    assert_sd_only_store_R9: assert (!(sd_sel && !xm_is_store))
      else $error("store-data forward without a store");
    // R4: the younger producer wins a double match
    assert_younger_wins_R4: assert (!(op_b_sel == 2'b10 && xm_wen && !xm_is_load
                                       && xm_dst == ex_src_b && xm_dst != ZERO_REG))
      else $error("older producer chosen over younger");
    // R1: encoding 2'b11 unused
    assert_sel_legal_R1: assert (op_a_sel != 2'b11 && op_b_sel != 2'b11)
      else $error("illegal select code");
  end
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int unsigned DW = 32;
  localparam int unsigned RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [RW-1:0] ex_src_a, ex_src_b, xm_dst, xm_sd_src, mw_dst;
  logic [DW-1:0] ex_rf_a, ex_rf_b, xm_result, xm_sd_val, mw_val;
  logic          xm_wen, xm_is_load, xm_is_store, mw_wen;
  logic [1:0]    op_a_sel, op_b_sel;
  logic [DW-1:0] op_a_val, op_b_val, sd_val;
  logic          sd_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit #(.DATA_W(DW), .REG_AW(RW)) dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .xm_dst(xm_dst), .xm_wen(xm_wen), .xm_is_load(xm_is_load), .xm_result(xm_result),
    .xm_is_store(xm_is_store), .xm_sd_src(xm_sd_src), .xm_sd_val(xm_sd_val),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_val(mw_val),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .op_a_val(op_a_val), .op_b_val(op_b_val),
    .sd_sel(sd_sel), .sd_val(sd_val)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    ex_src_a = 5'd1; ex_src_b = 5'd2;
    ex_rf_a = 32'h0000_0A0A; ex_rf_b = 32'h0000_0B0B;
    xm_dst = 5'd0; xm_wen = 0; xm_is_load = 0; xm_result = 32'hAAAA_0001;
    xm_is_store = 0; xm_sd_src = 5'd0; xm_sd_val = 32'h5D5D_0000;
    mw_dst = 5'd0; mw_wen = 0; mw_val = 32'hBBBB_0002;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(posedge clk); idle(); settle();
    chk("R1", "a_sel idle", {30'd0, op_a_sel}, 32'd0);
    chk("R1", "b_sel idle", {30'd0, op_b_sel}, 32'd0);
    chk("R1", "a_val idle", op_a_val, 32'h0000_0A0A);
    chk("R1", "b_val idle", op_b_val, 32'h0000_0B0B);
    chk("R7", "sd idle", sd_val, 32'h5D5D_0000);
    // distance three or more: writers no longer in flight
    @(posedge clk); idle(); ex_src_a = 5'd7; xm_dst = 5'd8; xm_wen = 1; mw_dst = 5'd9; mw_wen = 1; settle();
    chk("R1", "a_sel no match", {30'd0, op_a_sel}, 32'd0);
  endtask

  task automatic t_back_to_back();
    @(posedge clk); idle(); xm_dst = 5'd5; xm_wen = 1; ex_src_a = 5'd5; ex_src_b = 5'd6; settle();
    chk("R2", "a_sel xm", {30'd0, op_a_sel}, 32'd1);
    chk("R2", "a_val xm", op_a_val, 32'hAAAA_0001);
    chk("R2", "b_sel untouched", {30'd0, op_b_sel}, 32'd0);
    @(posedge clk); idle(); xm_dst = 5'd5; xm_wen = 1; ex_src_a = 5'd7; ex_src_b = 5'd5; settle();
    chk("R2", "b_sel xm", {30'd0, op_b_sel}, 32'd1);
    chk("R2", "b_val xm", op_b_val, 32'hAAAA_0001);
  endtask

  task automatic t_one_gap();
    @(posedge clk); idle(); mw_dst = 5'd8; mw_wen = 1; ex_src_a = 5'd8; settle();
    chk("R3", "a_sel mw", {30'd0, op_a_sel}, 32'd2);
    chk("R3", "a_val mw", op_a_val, 32'hBBBB_0002);
  endtask

  task automatic t_priority();
    @(posedge clk); idle(); xm_dst = 5'd3; xm_wen = 1; mw_dst = 5'd3; mw_wen = 1;
    ex_src_a = 5'd3; ex_src_b = 5'd3; settle();
    chk("R4", "a_sel both", {30'd0, op_a_sel}, 32'd1);
    chk("R4", "b_val both", op_b_val, 32'hAAAA_0001);
  endtask

  task automatic t_load_ahead();
    @(posedge clk); idle(); xm_dst = 5'd4; xm_wen = 1; xm_is_load = 1; ex_src_a = 5'd4; settle();
    chk("R5", "a_sel load xm", {30'd0, op_a_sel}, 32'd0);
    chk("R5", "a_val load xm", op_a_val, 32'h0000_0A0A);
    @(posedge clk); mw_dst = 5'd4; mw_wen = 1; settle();
    chk("R5", "a_sel load falls to mw", {30'd0, op_a_sel}, 32'd2);
  endtask

  task automatic t_zero_and_disabled();
    @(posedge clk); idle(); xm_wen = 1; mw_wen = 1; ex_src_a = 5'd0; ex_src_b = 5'd0;
    xm_is_store = 1; xm_sd_src = 5'd0; settle();
    chk("R6", "a_sel r0", {30'd0, op_a_sel}, 32'd0);
    chk("R6", "b_val r0", op_b_val, 32'h0000_0B0B);
    chk("R6", "sd_sel r0", {31'd0, sd_sel}, 32'd0);
    @(posedge clk); idle(); xm_dst = 5'd5; mw_dst = 5'd6; ex_src_a = 5'd5; ex_src_b = 5'd6;
    xm_is_store = 1; xm_sd_src = 5'd6; settle();
    chk("R6", "a_sel wen low", {30'd0, op_a_sel}, 32'd0);
    chk("R6", "b_sel wen low", {30'd0, op_b_sel}, 32'd0);
    chk("R6", "sd_sel wen low", {31'd0, sd_sel}, 32'd0);
  endtask

  task automatic t_load_then_store();
    @(posedge clk); idle(); xm_is_store = 1; xm_sd_src = 5'd9; xm_sd_val = 32'h1111_1111;
    mw_dst = 5'd9; mw_wen = 1; mw_val = 32'hCCCC_0003; settle();
    chk("R7", "sd_sel ld-st", {31'd0, sd_sel}, 32'd1);
    chk("R7", "sd_val ld-st", sd_val, 32'hCCCC_0003);
    @(posedge clk); mw_dst = 5'd10; settle();
    chk("R7", "sd_val no match", sd_val, 32'h1111_1111);
  endtask

  task automatic t_store_gap();
    @(posedge clk); idle(); ex_src_a = 5'd2; ex_src_b = 5'd10; mw_dst = 5'd10; mw_wen = 1; settle();
    chk("R8", "b_sel data", {30'd0, op_b_sel}, 32'd2);
    chk("R8", "a_sel base", {30'd0, op_a_sel}, 32'd0);
    chk("R8", "b_val data", op_b_val, 32'hBBBB_0002);
  endtask

  task automatic t_non_store();
    @(posedge clk); idle(); xm_is_store = 0; xm_sd_src = 5'd9; xm_sd_val = 32'h2222_2222;
    mw_dst = 5'd9; mw_wen = 1; settle();
    chk("R9", "sd_sel non-store", {31'd0, sd_sel}, 32'd0);
    chk("R9", "sd_val non-store", sd_val, 32'h2222_2222);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_back_to_back();
    t_one_gap();
    t_priority();
    t_load_ahead();
    t_zero_and_disabled();
    t_load_then_store();
    t_store_gap();
    t_non_store();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule